// File: doc/BRIEF.md
# Translation Descriptor Flag Updater

This block finishes a translation table walk by writing back the hardware-managed flags of the 64-bit descriptor that the walk used. The walker gives it a start pulse and a set of inputs. These are two eligibility marks (access flag and permission/dirty bit), the fault status so far, the access type, a write indication, the stage of the descriptor, and a flag that says this lookup is a stage-2 lookup made on behalf of a stage-1 walk. It also receives a walk-update override and the final physical address of the descriptor. From these the block decides whether the access flag, the permission bit, both, or neither must change.

When a change is needed, the block performs one locked read-modify-write of the 8-byte descriptor over a simple request/response memory port. It reads the descriptor, byte-reverses it if the endianness control of the active exception level selects big-endian, sets or clears the flag bits, and reverses it again before writing it back. When nothing needs to change, no memory traffic takes place and the incoming fault is handed straight back. In every case a one-cycle done pulse returns the resulting fault code.

Top module: `desc_flag_updater`

## Requirements
- R1: The access flag is updated when `afEligible` is 1 and either `faultIn` is 0 (no fault) or `afAnyway` is 1.
- R2: The permission bit is never updated while `faultIn` is non-zero or `apEligible` is 0.
- R3: An eligible permission update with no fault requires write permission. Write permission holds when `isWrite` is 1 or `accType` is 1, 2 or 3 (atomic, ordered, ordered-atomic read-write), and `s2ForS1Walk` is 0. Without write permission the update happens only if `walkUpdate` is 1.
- R4: For `accType` 4 (address-translation instruction), 5 (cache maintenance) or 6 (unprivileged cache maintenance), the permission update is suppressed even with write permission, unless `walkUpdate` is 1. Type 0 is an ordinary access and type 7 an instruction fetch.
- R5: When neither flag needs updating, no memory request is made and `doneValid` pulses on the first clock edge after the start, with `doneFault` equal to `faultIn`.
- R6: An update issues exactly one read, then one write, both to `descAddr`. `memLock` is high whenever a request is valid.
- R7: The endianness control is `endianEl3` for `exLevel` 3, `endianEl2` for `exLevel` 2, and `endianEl1` for any other level. When it is 1, the word is byte-reversed after the read and again before the write.
- R8: An access-flag update sets descriptor bit 10 (in descriptor byte order) to 1 and leaves the other bits unchanged.
- R9: A permission update sets descriptor bit 7 to 1 when `secondStage` is 1, and clears it to 0 when `secondStage` is 0.
- R10: An error response to the read ends the sequence with no write. An error response to either access returns fault code 0x10.
- R11: After reset `ready` is 1 and `doneValid` is 0. `doneValid` is high for exactly one cycle per start and, without a memory error, carries `faultIn` unchanged.
- R12: A memory request that is not yet accepted stays valid with the same address and direction until `memReqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when `ready` is 1 |
| ready | output | 1 | Block is idle and accepts a start |
| afEligible | input | 1 | Walker marks access flag as updatable |
| apEligible | input | 1 | Walker marks permission bit as updatable |
| faultIn | input | 6 | Fault code so far, 0 means none |
| accType | input | 3 | Access type code (see R3, R4) |
| isWrite | input | 1 | Access is a write |
| secondStage | input | 1 | Descriptor belongs to stage 2 |
| s2ForS1Walk | input | 1 | Stage-2 lookup made for a stage-1 walk |
| walkUpdate | input | 1 | Forces the permission update |
| afAnyway | input | 1 | Allows access-flag update despite a fault |
| exLevel | input | 2 | Active exception level |
| endianEl3 | input | 1 | Big-endian tables at level 3 |
| endianEl2 | input | 1 | Big-endian tables at level 2 |
| endianEl1 | input | 1 | Big-endian tables at lower levels |
| descAddr | input | 48 | Final descriptor address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 48 | Request address |
| memReqWdata | output | 64 | Write data |
| memLock | output | 1 | Locked read-modify-write in progress |
| memRspValid | input | 1 | Memory response valid |
| memRspErr | input | 1 | Memory response carries an error |
| memRspData | input | 64 | Read response data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 6 | Resulting fault code |

## Verification
On every cycle the assertions check the eligibility rules for both flags and the single-cycle done pulse. They also check the immediate completion when no update is needed, that each request is held until accepted and is always locked, and the value of bits 10 and 7 in little-endian write data. Only the bench scenarios can show the full decision table over access types, the write permission and walk-update cases, and the final memory word after a big-endian round trip at each exception level. The same holds for the skipped write after a read error and for correct completion under memory back-pressure.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
  localparam int DESC_W = 64;
  localparam int FAULT_W = 6;
  localparam logic [FAULT_W-1:0] FAULT_NONE = '0;
  localparam logic [FAULT_W-1:0] FAULT_EXT_ABORT = 6'h10;

  typedef enum logic [2:0] {
    ACC_NORMAL     = 3'd0,
    ACC_ATOMIC_RW  = 3'd1,
    ACC_ORDER_RW   = 3'd2,
    ACC_ORDER_ARW  = 3'd3,
    ACC_XLATE      = 3'd4,
    ACC_CMAINT     = 3'd5,
    ACC_CMAINT_UNP = 3'd6,
    ACC_IFETCH     = 3'd7
  } accType_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_DONE
  } fsmState_e;

  typedef struct packed {
    logic latchCtx;
    logic captureRead;
    logic applyMod;
    logic markAbort;
  } dpStrobes_t;
endpackage

// File: rtl/dfu_decide.sv
module dfu_decide
  import dfu_pkg::*;
(
  input  logic               afEligible,
  input  logic               apEligible,
  input  logic [FAULT_W-1:0] faultIn,
  input  logic [2:0]         accType,
  input  logic               isWrite,
  input  logic               s2ForS1Walk,
  input  logic               walkUpdate,
  input  logic               afAnyway,
  input  logic [1:0]         exLevel,
  input  logic               endianEl3,
  input  logic               endianEl2,
  input  logic               endianEl1,
  output logic               doAf,
  output logic               doAp,
  output logic               needUpdate,
  output logic               reverse
);
  logic noFault;
  logic rmwType;
  logic noDirtyType;
  logic writePerm;

  always_comb begin
    noFault     = (faultIn == FAULT_NONE);
    rmwType     = (accType == ACC_ATOMIC_RW) || (accType == ACC_ORDER_RW) ||
                  (accType == ACC_ORDER_ARW);
    noDirtyType = (accType == ACC_XLATE) || (accType == ACC_CMAINT) ||
                  (accType == ACC_CMAINT_UNP);
    writePerm   = (isWrite || rmwType) && !s2ForS1Walk;
    doAf        = afEligible && (noFault || afAnyway);
    doAp        = apEligible && noFault && ((writePerm && !noDirtyType) || walkUpdate);
    needUpdate  = doAf || doAp;
    case (exLevel)
      2'd3:    reverse = endianEl3;
      2'd2:    reverse = endianEl2;
      default: reverse = endianEl1;
    endcase
  end
endmodule

// File: rtl/dfu_ctrl.sv
module dfu_ctrl
  import dfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       needUpdate,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       memRspErr,
  output logic       ready,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       memLock,
  output logic       doneValid,
  output dpStrobes_t strobes
);
  fsmState_e state, stateNext;
  logic issued;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobes.latchCtx = 1'b1;
        stateNext = needUpdate ? ST_READ : ST_DONE;
      end
      ST_READ: if (memRspValid && issued) begin
        if (memRspErr) begin
          strobes.markAbort = 1'b1;
          stateNext = ST_DONE;
        end else begin
          strobes.captureRead = 1'b1;
          stateNext = ST_MODIFY;
        end
      end
      ST_MODIFY: begin
        strobes.applyMod = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: if (memRspValid && issued) begin
        strobes.markAbort = memRspErr;
        stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state <= stateNext;
      if (memReqValid && memReqReady) issued <= 1'b1;
      else if (memRspValid) issued <= 1'b0;
    end
  end

  always_comb begin
    ready       = (state == ST_IDLE);
    memReqValid = ((state == ST_READ) || (state == ST_WRITE)) && !issued;
    memReqWrite = (state == ST_WRITE);
    memLock     = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
    doneValid   = (state == ST_DONE);
  end

  // R5
  skip_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && start && !needUpdate) |=> (doneValid && !memReqValid));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite)));
  // R6
  req_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memLock);
endmodule

// File: rtl/dfu_datapath.sv
module dfu_datapath
  import dfu_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int AF_BIT = 10,
  parameter int AP_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [ADDR_W-1:0]  descAddr,
  input  logic [FAULT_W-1:0] faultIn,
  input  logic               doAf,
  input  logic               doAp,
  input  logic               secondStage,
  input  logic               reverse,
  input  logic [DESC_W-1:0]  memRspData,
  input  logic               memReqValid,
  input  logic               memReqWrite,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [DESC_W-1:0]  memReqWdata,
  output logic [FAULT_W-1:0] doneFault
);
  localparam int NBYTES = DESC_W / 8;

  logic [ADDR_W-1:0]  addrReg;
  logic [FAULT_W-1:0] faultReg;
  logic               afReg, apReg, secReg, revReg;
  logic [DESC_W-1:0]  descReg;
  logic [DESC_W-1:0]  rdSwap, wrSwap;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rdSwap[8*b +: 8] = memRspData[8*(NBYTES-1-b) +: 8];
    assign wrSwap[8*b +: 8] = descReg[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      faultReg <= FAULT_NONE;
      afReg    <= 1'b0;
      apReg    <= 1'b0;
      secReg   <= 1'b0;
      revReg   <= 1'b0;
      descReg  <= '0;
    end else begin
      if (strobes.latchCtx) begin
        addrReg  <= descAddr;
        faultReg <= faultIn;
        afReg    <= doAf;
        apReg    <= doAp;
        secReg   <= secondStage;
        revReg   <= reverse;
      end
      if (strobes.captureRead) descReg <= revReg ? rdSwap : memRspData;
      if (strobes.applyMod) begin
        if (afReg) descReg[AF_BIT] <= 1'b1;
        if (apReg) descReg[AP_BIT] <= secReg;
      end
      if (strobes.markAbort) faultReg <= FAULT_EXT_ABORT;
    end
  end

  assign memReqAddr  = addrReg;
  assign memReqWdata = revReg ? wrSwap : descReg;
  assign doneFault   = faultReg;

  // R8
  af_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && afReg && !revReg) |-> memReqWdata[AF_BIT]);
  // R9
  ap_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && apReg && !revReg) |-> (memReqWdata[AP_BIT] == secReg));
endmodule

// File: rtl/desc_flag_updater.sv
module desc_flag_updater
  import dfu_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output logic               ready,
  input  logic               afEligible,
  input  logic               apEligible,
  input  logic [FAULT_W-1:0] faultIn,
  input  logic [2:0]         accType,
  input  logic               isWrite,
  input  logic               secondStage,
  input  logic               s2ForS1Walk,
  input  logic               walkUpdate,
  input  logic               afAnyway,
  input  logic [1:0]         exLevel,
  input  logic               endianEl3,
  input  logic               endianEl2,
  input  logic               endianEl1,
  input  logic [ADDR_W-1:0]  descAddr,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [DESC_W-1:0]  memReqWdata,
  output logic               memLock,
  input  logic               memRspValid,
  input  logic               memRspErr,
  input  logic [DESC_W-1:0]  memRspData,
  output logic               doneValid,
  output logic [FAULT_W-1:0] doneFault
);
  logic doAf, doAp, needUpdate, reverse;
  dpStrobes_t strobes;

  dfu_decide u_decide (
    .afEligible(afEligible), .apEligible(apEligible), .faultIn(faultIn),
    .accType(accType), .isWrite(isWrite), .s2ForS1Walk(s2ForS1Walk),
    .walkUpdate(walkUpdate), .afAnyway(afAnyway), .exLevel(exLevel),
    .endianEl3(endianEl3), .endianEl2(endianEl2), .endianEl1(endianEl1),
    .doAf(doAf), .doAp(doAp), .needUpdate(needUpdate), .reverse(reverse)
  );

  dfu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .needUpdate(needUpdate),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .ready(ready), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memLock(memLock), .doneValid(doneValid), .strobes(strobes)
  );

  dfu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .descAddr(descAddr),
    .faultIn(faultIn), .doAf(doAf), .doAp(doAp), .secondStage(secondStage),
    .reverse(reverse), .memRspData(memRspData), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .doneFault(doneFault)
  );

  // R1
  af_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    doAf |-> (afEligible && ((faultIn == FAULT_NONE) || afAnyway)));
  // R2
  ap_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    doAp |-> (apEligible && (faultIn == FAULT_NONE)));
endmodule

// File: tb/sim_desc_flag_updater.sv
module sim_desc_flag_updater;
  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, afEligible = 0, apEligible = 0, isWrite = 0, secondStage = 0;
  logic s2ForS1Walk = 0, walkUpdate = 0, afAnyway = 0;
  logic endianEl3 = 0, endianEl2 = 0, endianEl1 = 0;
  logic [5:0] faultIn = 0;
  logic [2:0] accType = 0;
  logic [1:0] exLevel = 0;
  logic [47:0] descAddr = 48'h0000_1234_5678;
  logic ready, memReqValid, memReqWrite, memLock, doneValid;
  logic [47:0] memReqAddr;
  logic [63:0] memReqWdata;
  logic [5:0] doneFault;
  logic memReqReady = 1'b1, memRspValid = 0, memRspErr = 0;
  logic [63:0] memRspData = 0;

  desc_flag_updater u0 (.*);

  // memory model
  logic [63:0] memWord = 0, preloadVal = 0;
  logic preloadReq = 0, stallMode = 0, errRd = 0, errWr = 0, lockBad = 0;
  int nRd = 0, nWr = 0;
  logic [47:0] lastAddr = 0;
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    memRspErr   <= 1'b0;
    memReqReady <= stallMode ? ~memReqReady : 1'b1;
    if (preloadReq) begin
      memWord <= preloadVal; nRd <= 0; nWr <= 0; lockBad <= 0; lastAddr <= 0;
    end else if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      lastAddr <= memReqAddr;
      if (!memLock) lockBad <= 1'b1;
      if (memReqWrite) begin
        nWr <= nWr + 1;
        memRspErr <= errWr;
        if (!errWr) memWord <= memReqWdata;
      end else begin
        nRd <= nRd + 1;
        memRspErr <= errRd;
        memRspData <= memWord;
      end
    end
  end

  int total = 0, bad = 0;
  logic [5:0] gotFault;
  int gotCycles;

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    afEligible = 0; apEligible = 0; faultIn = 0; accType = 0; isWrite = 0;
    secondStage = 0; s2ForS1Walk = 0; walkUpdate = 0; afAnyway = 0; exLevel = 1;
    endianEl3 = 0; endianEl2 = 0; endianEl1 = 0; errRd = 0; errWr = 0; stallMode = 0;
  endtask

  task automatic go(input logic [63:0] init);
    @(negedge clk); preloadReq = 1; preloadVal = init;
    @(negedge clk); preloadReq = 0;
    start = 1;
    @(negedge clk); start = 0;
    gotCycles = 1;
    while (!doneValid && gotCycles < 100) begin @(negedge clk); gotCycles++; end
    gotFault = doneFault;
    if (!doneValid) check(0, "timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(ready === 1'b1, "R11 ready after reset", ready, 1);
    check(doneValid === 1'b0, "R11 done low after reset", doneValid, 0);
    check(memReqValid === 1'b0, "R11 no request after reset", memReqValid, 0);
  endtask

  task automatic t_skip();
    clr(); faultIn = 6'h05;
    go(64'h0);
    check(gotFault == 6'h05, "R5 fault returned", gotFault, 6'h05);
    check(gotCycles == 1, "R5 done after one cycle", gotCycles, 1);
    check(nRd == 0 && nWr == 0, "R5 no memory access", nRd + nWr, 0);
  endtask

  task automatic t_af_le();
    logic [63:0] init = 64'h0000_0000_0000_0003;
    clr(); afEligible = 1;
    go(init);
    check(memWord == (init | 64'h400), "R8 access flag set", memWord, init | 64'h400);
    check(nRd == 1 && nWr == 1, "R6 one read one write", nRd * 10 + nWr, 11);
    check(lastAddr == descAddr, "R6 address", lastAddr, descAddr);
    check(!lockBad, "R6 lock held", lockBad, 0);
    check(gotFault == 0, "R11 fault unchanged", gotFault, 0);
  endtask

  task automatic t_af_fault();
    clr(); afEligible = 1; faultIn = 6'h09;
    go(64'h0);
    check(nRd == 0 && gotFault == 6'h09, "R1 blocked by fault", nRd, 0);
    afAnyway = 1;
    go(64'h0);
    check(memWord == 64'h400, "R1 update anyway", memWord, 64'h400);
    check(gotFault == 6'h09, "R11 fault kept", gotFault, 6'h09);
  endtask

  task automatic t_ap_stage();
    clr(); apEligible = 1; isWrite = 1;
    go(64'h0000_0000_0000_00C0);
    check(memWord == 64'h40, "R9 stage 1 clears bit 7", memWord, 64'h40);
    secondStage = 1;
    go(64'h1);
    check(memWord == 64'h81, "R9 stage 2 sets bit 7", memWord, 64'h81);
  endtask

  task automatic t_ap_perm();
    clr(); apEligible = 1;
    go(64'h80);
    check(nRd == 0, "R3 read access no update", nRd, 0);
    walkUpdate = 1;
    go(64'h80);
    check(memWord == 64'h0, "R3 walk update forces", memWord, 0);
    clr(); apEligible = 1; isWrite = 1; s2ForS1Walk = 1;
    go(64'h80);
    check(nRd == 0, "R3 stage-2 for stage-1 walk no update", nRd, 0);
    clr(); apEligible = 1; accType = 3'd1;
    go(64'h80);
    check(memWord == 64'h0, "R3 atomic read-write updates", memWord, 0);
    clr(); apEligible = 1; accType = 3'd3;
    go(64'h80);
    check(memWord == 64'h0, "R3 ordered atomic updates", memWord, 0);
  endtask

  task automatic t_ap_suppress();
    clr(); apEligible = 1; isWrite = 1; accType = 3'd4;
    go(64'h80);
    check(nRd == 0, "R4 address translation suppressed", nRd, 0);
    accType = 3'd6;
    go(64'h80);
    check(nRd == 0, "R4 unprivileged maintenance suppressed", nRd, 0);
    accType = 3'd5; walkUpdate = 1;
    go(64'h80);
    check(memWord == 64'h0, "R4 walk update overrides", memWord, 0);
  endtask

  task automatic t_ap_fault();
    clr(); apEligible = 1; isWrite = 1; faultIn = 6'h0D; afAnyway = 1; walkUpdate = 1;
    go(64'h80);
    check(nRd == 0 && gotFault == 6'h0D, "R2 fault blocks permission", nRd, 0);
  endtask

  task automatic t_endian();
    logic [63:0] init = 64'h0123_4567_89AB_CDEF;
    logic [63:0] exp;
    clr(); afEligible = 1; exLevel = 2; endianEl2 = 1;
    go(init);
    exp = bswap(bswap(init) | 64'h400);
    check(memWord == exp, "R7 level 2 big-endian", memWord, exp);
    clr(); afEligible = 1; exLevel = 1; endianEl2 = 1; endianEl3 = 1;
    go(64'h0);
    check(memWord == 64'h400, "R7 level 1 little-endian", memWord, 64'h400);
    clr(); apEligible = 1; isWrite = 1; secondStage = 1; exLevel = 3; endianEl3 = 1;
    go(init);
    exp = bswap(bswap(init) | 64'h80);
    check(memWord == exp, "R7 level 3 big-endian", memWord, exp);
    clr(); afEligible = 1; exLevel = 0; endianEl1 = 1;
    go(64'h0);
    check(memWord == 64'h0004_0000_0000_0000, "R7 level 0 uses level-1 control",
          memWord, 64'h0004_0000_0000_0000);
  endtask

  task automatic t_errors();
    clr(); afEligible = 1; errRd = 1;
    go(64'h0);
    check(gotFault == 6'h10, "R10 read error code", gotFault, 6'h10);
    check(nWr == 0, "R10 no write after read error", nWr, 0);
    clr(); afEligible = 1; errWr = 1;
    go(64'h0);
    check(gotFault == 6'h10, "R10 write error code", gotFault, 6'h10);
  endtask

  task automatic t_stall();
    clr(); afEligible = 1; apEligible = 1; isWrite = 1; secondStage = 1; stallMode = 1;
    go(64'h0);
    check(memWord == 64'h480, "R12 result under back-pressure", memWord, 64'h480);
    check(nRd == 1 && nWr == 1, "R12 single accesses", nRd * 10 + nWr, 11);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_skip();
    t_af_le();
    t_af_fault();
    t_ap_stage();
    t_ap_perm();
    t_ap_suppress();
    t_ap_fault();
    t_endian();
    t_errors();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule